// File: doc/BRIEF.md
# Programmable Four-Input Logic Cell

This block is one programmable logic element of the kind that fills the array of a reconfigurable fabric. It takes four logic inputs and a carry input, and drives one cell output and a carry output. Its function comes from two 3-input lookup tables. In logic mode the two tables together act as a single 4-input function. In arithmetic mode each table produces one operand bit, and a full adder sums them with the incoming carry.

An output selector chooses between the function result taken straight through and a copy held in a D flip-flop. All 18 configuration bits enter through a serial shift chain while the configuration enable is high. While that enable is high, the flip-flop holds its value. A fabric would tile many of these cells and stitch their carry pins together into a chain.

Top module: `lcell_top`

## Requirements
- R1: While cfg_en_i is high, every rising clock edge shifts cfg_data_i into the configuration chain. After 18 shifts the first bit entered is table-0 entry 7 and the last bit entered is the output-select bit. The bits arrive in this order: table 0 entries 7 down to 0, table 1 entries 7 down to 0, the mode bit (1 = arithmetic), then the output-select bit (1 = registered).
- R2: Both tables are indexed by in_i[2:0], with entry number 4*in_i[2] + 2*in_i[1] + in_i[0]. In logic mode the function result is the table-0 entry when in_i[3] is 0 and the table-1 entry when in_i[3] is 1.
- R3: In arithmetic mode the function result is the XOR of the table-0 entry, the table-1 entry and carry_i. carry_o is the majority of those same three bits.
- R4: In logic mode carry_o is 0 for every input pattern.
- R5: With output-select 0, cell_o follows the function result in the same cycle, with no clock edge involved.
- R6: With output-select 1, cell_o shows the function result captured at the last rising edge on which cfg_en_i was low.
- R7: The flip-flop keeps its value on every edge on which cfg_en_i is high.
- R8: Pulling rst_ni low asynchronously clears the flip-flop and every configuration bit. cell_o and carry_o then read 0.
- R9: While cfg_en_i is low, the configuration does not change, whatever cfg_data_i does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_en_i | input | 1 | Configuration shift enable |
| cfg_data_i | input | 1 | Serial configuration bit |
| in_i | input | 4 | Logic inputs; [2:0] index the tables, [3] merges them in logic mode |
| carry_i | input | 1 | Carry input |
| cell_o | output | 1 | Cell output, combinational or registered |
| carry_o | output | 1 | Carry output |

## Verification
The hardest behaviour to reach is the registered output while a configuration load is in progress. As the bits shift through, the output-select and mode bits change value mid-stream, and the flip-flop must stay frozen at a result computed under the old configuration. The bench loads registered configurations that follow earlier registered ones, so every shift edge gets compared against a frozen value. It then runs long streams of random configurations with random inputs, carry and noise on the serial data line while the enable is low. A reset in the middle of a run checks that the configuration is cleared as well as the flip-flop.

// File: rtl/lcell_pkg.sv
package lcell_pkg;
  localparam int unsigned LUT_K_DEF = 3;

  typedef enum logic {
    MODE_LOGIC = 1'b0,
    MODE_ARITH = 1'b1
  } cell_mode_e;
endpackage

// File: rtl/lcell_cfg_chain.sv
module lcell_cfg_chain #(
  parameter int unsigned W = 18
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         data_i,
  output logic [W-1:0] cfg_o
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sr_q <= '0;
    else if (en_i) sr_q <= {sr_q[W-2:0], data_i};
  end

  assign cfg_o = sr_q;

  a_r1_shift_in: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> (sr_q[0] == $past(data_i)) && (sr_q[W-1:1] == $past(sr_q[W-2:0])));

  a_r9_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(sr_q));
endmodule

// File: rtl/lcell_lut.sv
module lcell_lut #(
  parameter int unsigned K = 3,
  localparam int unsigned N = 1 << K
) (
  input  logic [N-1:0] table_i,
  input  logic [K-1:0] addr_i,
  output logic         bit_o
);
  assign bit_o = table_i[addr_i];
endmodule

// File: rtl/lcell_func.sv
module lcell_func
  import lcell_pkg::*;
(
  input  cell_mode_e mode_i,
  input  logic       lo_i,
  input  logic       hi_i,
  input  logic       sel_i,
  input  logic       carry_i,
  output logic       res_o,
  output logic       carry_o
);
  logic sum, maj;

  always_comb begin
    sum = lo_i ^ hi_i ^ carry_i;
    maj = (lo_i & hi_i) | (carry_i & (lo_i ^ hi_i));
    if (mode_i == MODE_ARITH) begin
      res_o   = sum;
      carry_o = maj;
    end else begin
      res_o   = sel_i ? hi_i : lo_i;
      carry_o = 1'b0;
    end
  end
endmodule

// File: rtl/lcell_top.sv
module lcell_top
  import lcell_pkg::*;
#(
  parameter int unsigned LUT_K = LUT_K_DEF,
  localparam int unsigned LUT_N = 1 << LUT_K,
  localparam int unsigned CFG_W = 2 * LUT_N + 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cfg_en_i,
  input  logic           cfg_data_i,
  input  logic [LUT_K:0] in_i,
  input  logic           carry_i,
  output logic           cell_o,
  output logic           carry_o
);
  logic [CFG_W-1:0] cfg_q;
  logic [1:0]       lut_bit;
  cell_mode_e       mode;
  logic             osel;
  logic             func_res;
  logic             ff_q;

  lcell_cfg_chain #(.W(CFG_W)) u_chain (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (cfg_en_i),
    .data_i (cfg_data_i),
    .cfg_o  (cfg_q)
  );

  // table 0 sits at the top of the chain, table 1 below it
  for (genvar g = 0; g < 2; g++) begin : g_lut
    lcell_lut #(.K(LUT_K)) u_lut (
      .table_i (cfg_q[CFG_W-1-g*LUT_N -: LUT_N]),
      .addr_i  (in_i[LUT_K-1:0]),
      .bit_o   (lut_bit[g])
    );
  end

  assign mode = cell_mode_e'(cfg_q[1]);
  assign osel = cfg_q[0];

  lcell_func u_func (
    .mode_i  (mode),
    .lo_i    (lut_bit[0]),
    .hi_i    (lut_bit[1]),
    .sel_i   (in_i[LUT_K]),
    .carry_i (carry_i),
    .res_o   (func_res),
    .carry_o (carry_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ff_q <= 1'b0;
    else if (!cfg_en_i) ff_q <= func_res;
  end

  assign cell_o = osel ? ff_q : func_res;

  a_r7_ff_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_en_i |=> $stable(ff_q));

  a_r6_ff_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_en_i |=> ff_q == $past(func_res));

  a_r4_carry_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_LOGIC) |-> !carry_o);
endmodule

// File: tb/lcell_top_bench.sv
module lcell_top_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cfg_en_i = 1'b0;
  logic       cfg_data_i = 1'b0;
  logic [3:0] in_i = '0;
  logic       carry_i = 1'b0;
  logic       cell_o, carry_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  bit m_q[$];
  bit m_ff;

  always #2 clk_i = ~clk_i;

  lcell_top u_lcell_top (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_en_i(cfg_en_i), .cfg_data_i(cfg_data_i),
    .in_i(in_i), .carry_i(carry_i), .cell_o(cell_o), .carry_o(carry_o)
  );

  function automatic void model_clear();
    m_q.delete();
    for (int i = 0; i < 18; i++) m_q.push_back(1'b0);
    m_ff = 1'b0;
  endfunction

  // queue index 0 = oldest bit = table-0 entry 7
  function automatic void model_eval(output bit f, output bit co);
    int idx = in_i[2] * 4 + in_i[1] * 2 + in_i[0];
    bit l0 = m_q[7 - idx];
    bit l1 = m_q[15 - idx];
    int s;
    if (m_q[16]) begin
      s  = l0 + l1 + carry_i;
      f  = s % 2;
      co = s >= 2;
    end else begin
      f  = in_i[3] ? l1 : l0;
      co = 1'b0;
    end
  endfunction

  task automatic compare(string tag);
    bit f, co, exp_out;
    model_eval(f, co);
    exp_out = m_q[17] ? m_ff : f;
    n_cmp++;
    if (cell_o !== exp_out || carry_o !== co) begin
      n_bad++;
      $display("FAIL %s: cell_o=%b carry_o=%b expected cell_o=%b carry_o=%b",
               tag, cell_o, carry_o, exp_out, co);
    end
  endtask

  task automatic step(bit en, bit dat, logic [3:0] in, bit cin, string tag);
    bit f, co;
    @(negedge clk_i);
    cfg_en_i = en; cfg_data_i = dat; in_i = in; carry_i = cin;
    #1 compare(tag);
    model_eval(f, co);
    @(posedge clk_i);
    if (en) begin
      void'(m_q.pop_front());
      m_q.push_back(dat);
    end else begin
      m_ff = f;
    end
  endtask

  task automatic load(logic [7:0] t0, logic [7:0] t1, bit mode, bit osel);
    logic [17:0] v = {t0, t1, mode, osel};
    for (int i = 17; i >= 0; i--) step(1'b1, v[i], 4'($urandom), 1'($urandom), "R7");
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1 model_clear();
    compare("R8");
    @(negedge clk_i);
    compare("R8");
    rst_ni = 1'b1;
  endtask

  initial begin
    model_clear();
    #1 compare("R8");
    @(negedge clk_i);
    compare("R8");
    rst_ni = 1'b1;

    load(8'hE8, 8'h96, 1'b0, 1'b0);
    for (int i = 0; i < 16; i++) step(1'b0, 1'b0, 4'(i), 1'(i), "R2 R4 R5");

    load(8'h5A, 8'hC3, 1'b0, 1'b1);
    for (int i = 0; i < 16; i++) step(1'b0, 1'b1, 4'(i), 1'b0, "R6");
    load(8'h0F, 8'hF1, 1'b1, 1'b1);
    for (int i = 0; i < 16; i++) step(1'b0, 1'(i), 4'(i), 1'(i >> 1), "R6 R3");

    load(8'hAC, 8'h35, 1'b1, 1'b0);
    for (int i = 0; i < 32; i++) step(1'b0, 1'($urandom), 4'(i), 1'(i >> 3), "R3");

    for (int r = 0; r < 40; r++) begin
      load(8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom));
      for (int i = 0; i < 30; i++)
        step(1'b0, 1'($urandom), 4'($urandom), 1'($urandom), "R1 R9");
      if (r == 20) do_reset();
    end

    do_reset();
    for (int i = 0; i < 8; i++) step(1'b0, 1'b1, 4'(i * 2), 1'b1, "R8 R9");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule